// File: doc/BRIEF.md
# Cross-Context Register Read Unit

This unit executes the read half of a thread-context transfer instruction. It copies one register from another hardware thread context into a general register of the issuing thread. It takes a 32-bit instruction word and the index of the target context, which comes from a control register. It also takes the issuer's processor binding, the privilege and configuration inputs, and the per-context halted and binding state.

The unit then runs an ordered chain of checks:

- encoding,
- coprocessor usability,
- binding,
- context range,
- selection validity.

After the checks it either answers immediately or issues one read on an external register-bank port. That port has one cycle of latency. The unit extracts the requested 32-bit half and returns it with a one-cycle write strobe for the destination register.

Requests use a valid/ready handshake. Ready stays low while a request needs a bank read from a context that is not halted. A request to a running context therefore stalls for as long as that context runs.

Control is a three-state machine:

- `ST_IDLE` waits for a request. Transition IDLE→READ is taken on acceptance when a bank read is needed. Transition IDLE→RESP is taken on acceptance when the answer is already known.
- `ST_READ` drives the bank read port for one cycle. Transition READ→RESP is unconditional.
- `ST_RESP` presents the response for one cycle. Transition RESP→IDLE is unconditional.

Top module: `xctx_read_unit`

## Requirements
- R1: The instruction is laid out as bits 31:26 major opcode (must be 6'b010000), 25:21 sub-op (must be 5'b01000), 20:16 rt, 15:11 rd, 10:6 rx, bit 5 u, bit 4 h, bit 3 reserved (must be 0), 2:0 sel. Any mismatch gives resp_rsvd=1, rd_we=0 and no bank read.
- R2: A well-formed request with cop_en=0 gives resp_unusable=1, rd_we=0 and no bank read.
- R3: The binding check comes first among the data checks. If multi_vpe_priv=0 and an existing target context (index < NUM_CTX) is bound to a processor other than issuer_vpe, rd_data is all ones with rd_we=1 and no bank read.
- R4: Otherwise, a target index above cfg_top_ctx, or not below NUM_CTX, returns all ones with rd_we=1 and no bank read.
- R5: With u=0 the unit reads bank code 0 (system-control registers) at address {2'b00, rt, sel}.
- R6: With u=1 the bank code and address depend on sel:
  - sel=0 reads bank 1 (general) at {5'b0, rt}.
  - sel=3 reads bank 4 (FP control) at {5'b0, rt}.
  - sel=4 reads bank 5 (coprocessor-2 data) at {rx, rt}.
  - sel=5 reads bank 6 (coprocessor-2 control) at {rx, rt}.
- R7: With u=1 and sel=1, bank 2 (accumulators) is read at {5'b0, rt} only for rt in {0,1,2,4,5,6,8,9,10,12,13,14,16}. Any other rt is undefined.
- R8: With u=1 and sel=2, bank 3 (floating point) is read at {5'b0, rt}. When fp_split=0 (register widths match), h=1 is undefined.
- R9: The 64-bit bank word is reduced to bits 63:32 when h=1 and to bits 31:0 when h=0.
- R10: Undefined selections return rd_data=0 with resp_undef=1 and rd_we=1, without a bank read. Undefined selections are u=1 with sel 6 or 7, and the cases of R7 and R8.
- R11: For a request that needs a bank read, req_ready is low while the target's ctx_halted bit is 0. req_ready rises in the same cycle that bit becomes 1.
- R12: The response appears one cycle after acceptance without a bank read, and two cycles after acceptance with one. resp_valid and rd_we last exactly one cycle, and rd_addr equals the rd field.
- R13: After reset, resp_valid, rd_we and bank_rd_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| instr | input | 32 | Instruction word |
| ctl_target_ctx | input | CTX_IDX_W | Target context index from the control register |
| cfg_top_ctx | input | CTX_IDX_W | Highest configured context number |
| issuer_vpe | input | VPE_W | Processor the issuing thread is bound to |
| multi_vpe_priv | input | 1 | Privilege to read contexts of other processors |
| ctx_bind | input | NUM_CTX*VPE_W | Processor binding of each context |
| ctx_halted | input | NUM_CTX | Halted flag of each context |
| cop_en | input | 1 | Coprocessor-0 access usable |
| fp_split | input | 1 | 1: 32-bit general with 64-bit FP registers |
| bank_rd_en | output | 1 | Bank read strobe |
| bank_rd_ctx | output | CTX_IDX_W | Context of the bank read |
| bank_rd_sel | output | 3 | Bank code (see R5 to R8) |
| bank_rd_addr | output | 10 | Address within the bank |
| bank_rd_data | input | 64 | Read data, valid the cycle after the strobe |
| resp_valid | output | 1 | Response cycle |
| rd_we | output | 1 | Destination register write strobe |
| rd_addr | output | 5 | Destination register number |
| rd_data | output | 32 | Write data |
| resp_undef | output | 1 | Selection was undefined |
| resp_rsvd | output | 1 | Reserved encoding |
| resp_unusable | output | 1 | Coprocessor unusable |

## Verification
The bench builds the unit with its defaults: six contexts, a 4-bit context index and a single binding bit. The index field can therefore reach values above both the configured top and the physical context count. Randomising cfg_top_ctx between 2 and 7 exercises both out-of-range conditions separately, and random bindings collide with the issuer often enough to hit the binding check. Directed cases cover:

- a stall held on a running context,
- a denied request to a running context, which must not stall,
- every accumulator index from 0 to 31,
- the floating-point half rule in both width modes.

// File: rtl/xcr_pkg.sv
package xcr_pkg;

    localparam logic [5:0] MAJOR_OP = 6'b010000;
    localparam logic [4:0] SUB_OP   = 5'b01000;
    localparam int         ADDR_W   = 10;

    typedef enum logic [2:0] {
        BK_CP0 = 3'd0,
        BK_GPR = 3'd1,
        BK_ACC = 3'd2,
        BK_FPR = 3'd3,
        BK_FCR = 3'd4,
        BK_C2D = 3'd5,
        BK_C2C = 3'd6
    } bank_e;

    typedef enum logic [2:0] {
        OC_DATA = 3'd0,
        OC_ONES = 3'd1,
        OC_ZERO = 3'd2,
        OC_RSVD = 3'd3,
        OC_UNUS = 3'd4
    } outcome_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_RESP = 2'd2
    } state_e;

    typedef struct packed {
        outcome_e          oc;
        bank_e             bank;
        logic [ADDR_W-1:0] addr;
        logic              hi;
        logic [4:0]        rd;
    } plan_t;

endpackage

// File: rtl/xcr_decode.sv
module xcr_decode
    import xcr_pkg::*;
#(
    parameter int CTX_IDX_W = 4,
    parameter int NUM_CTX   = 6,
    parameter int VPE_W     = 1
) (
    input  logic [31:0]              instr,
    input  logic [CTX_IDX_W-1:0]     target,
    input  logic [CTX_IDX_W-1:0]     top_ctx,
    input  logic [VPE_W-1:0]         issuer_vpe,
    input  logic                     multi_vpe_priv,
    input  logic [NUM_CTX*VPE_W-1:0] ctx_bind,
    input  logic                     cop_en,
    input  logic                     fp_split,
    output plan_t                    plan
);

    logic [5:0] f_major;
    logic [4:0] f_sub, f_rt, f_rd, f_rx;
    logic       f_u, f_h, f_zero;
    logic [2:0] f_sel;

    assign f_major = instr[31:26];
    assign f_sub   = instr[25:21];
    assign f_rt    = instr[20:16];
    assign f_rd    = instr[15:11];
    assign f_rx    = instr[10:6];
    assign f_u     = instr[5];
    assign f_h     = instr[4];
    assign f_zero  = instr[3];
    assign f_sel   = instr[2:0];

    logic foreign;
    logic out_of_range;
    logic acc_ok;

    always_comb begin
        foreign = 1'b0;
        for (int i = 0; i < NUM_CTX; i++) begin
            if (target == CTX_IDX_W'(i) &&
                ctx_bind[i*VPE_W +: VPE_W] != issuer_vpe)
                foreign = 1'b1;
        end
    end

    assign out_of_range = (target > top_ctx) || (int'(target) >= NUM_CTX);
    assign acc_ok       = (f_rt <= 5'd16) && (f_rt[1:0] != 2'b11);

    always_comb begin
        plan.oc   = OC_DATA;
        plan.bank = BK_CP0;
        plan.addr = '0;
        plan.hi   = f_h;
        plan.rd   = f_rd;
        if (f_major != MAJOR_OP || f_sub != SUB_OP || f_zero) begin
            plan.oc = OC_RSVD;
        end else if (!cop_en) begin
            plan.oc = OC_UNUS;
        end else if (!multi_vpe_priv && foreign) begin
            plan.oc = OC_ONES;
        end else if (out_of_range) begin
            plan.oc = OC_ONES;
        end else if (!f_u) begin
            plan.bank = BK_CP0;
            plan.addr = {2'b00, f_rt, f_sel};
        end else begin
            unique case (f_sel)
                3'd0: begin
                    plan.bank = BK_GPR;
                    plan.addr = {5'b0, f_rt};
                end
                3'd1: begin
                    plan.bank = BK_ACC;
                    plan.addr = {5'b0, f_rt};
                    if (!acc_ok) plan.oc = OC_ZERO;
                end
                3'd2: begin
                    plan.bank = BK_FPR;
                    plan.addr = {5'b0, f_rt};
                    if (!fp_split && f_h) plan.oc = OC_ZERO;
                end
                3'd3: begin
                    plan.bank = BK_FCR;
                    plan.addr = {5'b0, f_rt};
                end
                3'd4: begin
                    plan.bank = BK_C2D;
                    plan.addr = {f_rx, f_rt};
                end
                3'd5: begin
                    plan.bank = BK_C2C;
                    plan.addr = {f_rx, f_rt};
                end
                default: plan.oc = OC_ZERO;
            endcase
        end
    end

endmodule

// File: rtl/xcr_fsm.sv
module xcr_fsm
    import xcr_pkg::*;
#(
    parameter int CTX_IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  plan_t                plan_in,
    input  logic                 tgt_halted,
    input  logic [CTX_IDX_W-1:0] target,
    output logic                 req_ready,
    output logic                 bank_rd_en,
    output logic [CTX_IDX_W-1:0] bank_rd_ctx,
    output logic [2:0]           bank_rd_sel,
    output logic [ADDR_W-1:0]    bank_rd_addr,
    output logic                 resp_valid,
    output logic                 rd_we,
    output logic [4:0]           rd_addr,
    output logic                 resp_undef,
    output logic                 resp_rsvd,
    output logic                 resp_unusable,
    output outcome_e             oc_q,
    output logic                 hi_q
);

    state_e               state, nxt;
    plan_t                plan_q;
    logic [CTX_IDX_W-1:0] ctx_q;
    logic                 needs_read;
    logic                 accept;

    assign needs_read = (plan_in.oc == OC_DATA);
    assign req_ready  = (state == ST_IDLE) && (!needs_read || tgt_halted);
    assign accept     = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            plan_q <= '0;
            ctx_q  <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                plan_q <= plan_in;
                ctx_q  <= target;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (accept) nxt = needs_read ? ST_READ : ST_RESP;
            ST_READ: nxt = ST_RESP;
            ST_RESP: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        bank_rd_en    = (state == ST_READ);
        bank_rd_ctx   = ctx_q;
        bank_rd_sel   = plan_q.bank;
        bank_rd_addr  = plan_q.addr;
        resp_valid    = (state == ST_RESP);
        rd_we         = 1'b0;
        resp_undef    = 1'b0;
        resp_rsvd     = 1'b0;
        resp_unusable = 1'b0;
        rd_addr       = plan_q.rd;
        oc_q          = plan_q.oc;
        hi_q          = plan_q.hi;
        if (state == ST_RESP) begin
            unique case (plan_q.oc)
                OC_DATA, OC_ONES: rd_we = 1'b1;
                OC_ZERO: begin
                    rd_we      = 1'b1;
                    resp_undef = 1'b1;
                end
                OC_RSVD: resp_rsvd     = 1'b1;
                OC_UNUS: resp_unusable = 1'b1;
                default: rd_we = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/xcr_result.sv
module xcr_result
    import xcr_pkg::*;
(
    input  outcome_e    oc,
    input  logic        hi,
    input  logic [63:0] word,
    output logic [31:0] data
);

    always_comb begin
        unique case (oc)
            OC_DATA: data = hi ? word[63:32] : word[31:0];
            OC_ONES: data = '1;
            default: data = '0;
        endcase
    end

endmodule

// File: rtl/xctx_read_unit.sv
module xctx_read_unit
    import xcr_pkg::*;
#(
    parameter int CTX_IDX_W = 4,
    parameter int NUM_CTX   = 6,
    parameter int VPE_W     = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [31:0]              instr,
    input  logic [CTX_IDX_W-1:0]     ctl_target_ctx,
    input  logic [CTX_IDX_W-1:0]     cfg_top_ctx,
    input  logic [VPE_W-1:0]         issuer_vpe,
    input  logic                     multi_vpe_priv,
    input  logic [NUM_CTX*VPE_W-1:0] ctx_bind,
    input  logic [NUM_CTX-1:0]       ctx_halted,
    input  logic                     cop_en,
    input  logic                     fp_split,
    output logic                     bank_rd_en,
    output logic [CTX_IDX_W-1:0]     bank_rd_ctx,
    output logic [2:0]               bank_rd_sel,
    output logic [ADDR_W-1:0]        bank_rd_addr,
    input  logic [63:0]              bank_rd_data,
    output logic                     resp_valid,
    output logic                     rd_we,
    output logic [4:0]               rd_addr,
    output logic [31:0]              rd_data,
    output logic                     resp_undef,
    output logic                     resp_rsvd,
    output logic                     resp_unusable
);

    plan_t    plan;
    logic     tgt_halted;
    outcome_e oc_q;
    logic     hi_q;

    always_comb begin
        tgt_halted = 1'b0;
        for (int i = 0; i < NUM_CTX; i++) begin
            if (ctl_target_ctx == CTX_IDX_W'(i)) tgt_halted = ctx_halted[i];
        end
    end

    xcr_decode #(
        .CTX_IDX_W(CTX_IDX_W),
        .NUM_CTX  (NUM_CTX),
        .VPE_W    (VPE_W)
    ) decode_i (
        .instr         (instr),
        .target        (ctl_target_ctx),
        .top_ctx       (cfg_top_ctx),
        .issuer_vpe    (issuer_vpe),
        .multi_vpe_priv(multi_vpe_priv),
        .ctx_bind      (ctx_bind),
        .cop_en        (cop_en),
        .fp_split      (fp_split),
        .plan          (plan)
    );

    xcr_fsm #(
        .CTX_IDX_W(CTX_IDX_W)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .plan_in      (plan),
        .tgt_halted   (tgt_halted),
        .target       (ctl_target_ctx),
        .req_ready    (req_ready),
        .bank_rd_en   (bank_rd_en),
        .bank_rd_ctx  (bank_rd_ctx),
        .bank_rd_sel  (bank_rd_sel),
        .bank_rd_addr (bank_rd_addr),
        .resp_valid   (resp_valid),
        .rd_we        (rd_we),
        .rd_addr      (rd_addr),
        .resp_undef   (resp_undef),
        .resp_rsvd    (resp_rsvd),
        .resp_unusable(resp_unusable),
        .oc_q         (oc_q),
        .hi_q         (hi_q)
    );

    xcr_result result_i (
        .oc  (oc_q),
        .hi  (hi_q),
        .word(bank_rd_data),
        .data(rd_data)
    );

endmodule

// File: rtl/xctx_read_unit_chk.sv
module xctx_read_unit_chk #(
    parameter int CTX_IDX_W = 4,
    parameter int NUM_CTX   = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 bank_rd_en,
    input logic [CTX_IDX_W-1:0] bank_rd_ctx,
    input logic [NUM_CTX-1:0]   ctx_halted,
    input logic                 resp_valid,
    input logic                 rd_we,
    input logic [31:0]          rd_data,
    input logic                 resp_undef
);

    logic rd_ctx_halted;

    always_comb begin
        rd_ctx_halted = 1'b0;
        for (int i = 0; i < NUM_CTX; i++) begin
            if (bank_rd_ctx == CTX_IDX_W'(i)) rd_ctx_halted = ctx_halted[i];
        end
    end

    // R12
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |=> !rd_we);

    // R12
    we_in_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> resp_valid);

    // R12
    read_then_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_rd_en |=> (resp_valid && !bank_rd_en));

    // R11
    read_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_rd_en |-> rd_ctx_halted);

    // R12
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_undef |-> (rd_we && rd_data == 32'd0));

endmodule

bind xctx_read_unit xctx_read_unit_chk #(
    .CTX_IDX_W(CTX_IDX_W),
    .NUM_CTX  (NUM_CTX)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .bank_rd_en (bank_rd_en),
    .bank_rd_ctx(bank_rd_ctx),
    .ctx_halted (ctx_halted),
    .resp_valid (resp_valid),
    .rd_we      (rd_we),
    .rd_data    (rd_data),
    .resp_undef (resp_undef)
);

// File: tb/xctx_read_unit_tb_top.sv
module xctx_read_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCTX       = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] instr = '0;
    logic [3:0]  tgt = '0;
    logic [3:0]  top_ctx = 4'd5;
    logic [0:0]  issuer = 1'b0;
    logic        priv = 1'b1;
    logic [5:0]  bindv = '0;
    logic [5:0]  halted = '1;
    logic        cop_en = 1'b1;
    logic        fp_split = 1'b1;
    logic        bank_rd_en;
    logic [3:0]  bank_rd_ctx;
    logic [2:0]  bank_rd_sel;
    logic [9:0]  bank_rd_addr;
    logic [63:0] bank_rd_data = '0;
    logic        resp_valid, rd_we, resp_undef, resp_rsvd, resp_unusable;
    logic [4:0]  rd_addr;
    logic [31:0] rd_data;

    int checks = 0;
    int failures = 0;

    typedef struct packed {
        logic        rsvd;
        logic        unus;
        logic        we;
        logic        undef;
        logic        rd;
        logic [31:0] data;
    } exp_t;

    always #(CLK_PERIOD/2) clk = ~clk;

    xctx_read_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .instr(instr), .ctl_target_ctx(tgt), .cfg_top_ctx(top_ctx),
        .issuer_vpe(issuer), .multi_vpe_priv(priv), .ctx_bind(bindv),
        .ctx_halted(halted), .cop_en(cop_en), .fp_split(fp_split),
        .bank_rd_en(bank_rd_en), .bank_rd_ctx(bank_rd_ctx),
        .bank_rd_sel(bank_rd_sel), .bank_rd_addr(bank_rd_addr),
        .bank_rd_data(bank_rd_data), .resp_valid(resp_valid), .rd_we(rd_we),
        .rd_addr(rd_addr), .rd_data(rd_data), .resp_undef(resp_undef),
        .resp_rsvd(resp_rsvd), .resp_unusable(resp_unusable)
    );

    function automatic logic [63:0] bank_word(logic [3:0] c, logic [2:0] b, logic [9:0] a);
        return {8'hA5, c, 1'b0, b, 6'h00, a, 8'h3C, c, 1'b0, b, a, 6'h15};
    endfunction

    always @(posedge clk) begin
        if (bank_rd_en) bank_rd_data <= bank_word(bank_rd_ctx, bank_rd_sel, bank_rd_addr);
    end

    function automatic logic [31:0] mk(logic [4:0] rt, logic [4:0] rd, logic [4:0] rx,
                                       logic u, logic h, logic [2:0] sel);
        return {6'b010000, 5'b01000, rt, rd, rx, u, h, 1'b0, sel};
    endfunction

    function automatic exp_t expect_of(logic [31:0] ins, logic [3:0] t);
        exp_t e;
        logic [4:0] rt, rx;
        logic u, h;
        logic [2:0] sel, bk;
        logic [9:0] ad;
        logic [63:0] w;
        e = '0;
        rt = ins[20:16]; rx = ins[10:6]; u = ins[5]; h = ins[4]; sel = ins[2:0];
        bk = 3'd0; ad = '0;
        if (ins[31:26] != 6'b010000 || ins[25:21] != 5'b01000 || ins[3]) begin
            e.rsvd = 1'b1; return e;
        end
        if (!cop_en) begin e.unus = 1'b1; return e; end
        e.we = 1'b1;
        if ((!priv && t < 4'd6 && bindv[t[2:0]] != issuer[0]) || t > top_ctx || t >= 4'd6) begin
            e.data = 32'hFFFF_FFFF; return e;
        end
        if (!u) begin
            bk = 3'd0; ad = {2'b00, rt, sel};
        end else begin
            case (sel)
                3'd0: begin bk = 3'd1; ad = {5'b0, rt}; end
                3'd1: begin
                    bk = 3'd2; ad = {5'b0, rt};
                    if (!(rt inside {0,1,2,4,5,6,8,9,10,12,13,14,16})) e.undef = 1'b1;
                end
                3'd2: begin bk = 3'd3; ad = {5'b0, rt}; if (!fp_split && h) e.undef = 1'b1; end
                3'd3: begin bk = 3'd4; ad = {5'b0, rt}; end
                3'd4: begin bk = 3'd5; ad = {rx, rt}; end
                3'd5: begin bk = 3'd6; ad = {rx, rt}; end
                default: e.undef = 1'b1;
            endcase
        end
        if (e.undef) begin e.data = '0; return e; end
        e.rd = 1'b1;
        w = bank_word(t, bk, ad);
        e.data = h ? w[63:32] : w[31:0];
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_req(input exp_t e, input logic [4:0] rdf, input string tag);
        int guard = 0;
        int lat = 0;
        while (!req_ready && guard < 50) begin @(negedge clk); guard++; end
        check(req_ready, {tag, " R11 ready"}, 64'(req_ready), 64'd1);
        @(posedge clk); #1 req_valid = 1'b0;
        do begin @(negedge clk); lat++; end while (!resp_valid && lat < 10);
        check(lat == (e.rd ? 2 : 1), {tag, " R12 latency"}, 64'(lat), e.rd ? 64'd2 : 64'd1);
        check(rd_we == e.we, {tag, " R12 rd_we"}, 64'(rd_we), 64'(e.we));
        if (e.we) begin
            check(rd_data == e.data, {tag, " R9 rd_data"}, 64'(rd_data), 64'(e.data));
            check(rd_addr == rdf, {tag, " R12 rd_addr"}, 64'(rd_addr), 64'(rdf));
        end
        check(resp_undef == e.undef, {tag, " R10 undef"}, 64'(resp_undef), 64'(e.undef));
        check(resp_rsvd == e.rsvd, {tag, " R1 rsvd"}, 64'(resp_rsvd), 64'(e.rsvd));
        check(resp_unusable == e.unus, {tag, " R2 unusable"}, 64'(resp_unusable), 64'(e.unus));
        @(negedge clk);
        check(!rd_we && !resp_valid, {tag, " R12 single pulse"}, 64'({rd_we, resp_valid}), 64'd0);
    endtask

    task automatic do_req(input logic [31:0] ins, input logic [3:0] t, input string tag);
        exp_t e;
        @(negedge clk);
        instr = ins; tgt = t;
        e = expect_of(ins, t);
        req_valid = 1'b1;
        finish_req(e, ins[15:11], tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] ins;
        exp_t e;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        // R13 reset state
        check(!resp_valid && !rd_we && !bank_rd_en, "R13 reset outputs",
              64'({resp_valid, rd_we, bank_rd_en}), 64'd0);
        rst_n = 1'b1;

        // R5 system-control read, both halves (R9)
        do_req(mk(5'd12, 5'd3, 5'd0, 1'b0, 1'b0, 3'd2), 4'd1, "R5 cp0 lo");
        do_req(mk(5'd12, 5'd3, 5'd0, 1'b0, 1'b1, 3'd2), 4'd1, "R5 cp0 hi");
        // R6 general, FP control, coprocessor-2 banks
        do_req(mk(5'd31, 5'd7, 5'd9, 1'b1, 1'b0, 3'd0), 4'd2, "R6 gpr");
        do_req(mk(5'd4, 5'd7, 5'd9, 1'b1, 1'b1, 3'd3), 4'd0, "R6 fcr");
        do_req(mk(5'd17, 5'd8, 5'd21, 1'b1, 1'b0, 3'd4), 4'd3, "R6 c2d");
        do_req(mk(5'd17, 5'd8, 5'd21, 1'b1, 1'b1, 3'd5), 4'd5, "R6 c2c");
        // R7 every accumulator index
        for (int k = 0; k < 32; k++)
            do_req(mk(5'(k), 5'd1, 5'd0, 1'b1, k[0], 3'd1), 4'd4, "R7 acc");
        // R8 FP half rule in both width modes
        fp_split = 1'b0;
        do_req(mk(5'd6, 5'd2, 5'd0, 1'b1, 1'b1, 3'd2), 4'd1, "R8 fpr match hi");
        do_req(mk(5'd6, 5'd2, 5'd0, 1'b1, 1'b0, 3'd2), 4'd1, "R8 fpr match lo");
        fp_split = 1'b1;
        do_req(mk(5'd6, 5'd2, 5'd0, 1'b1, 1'b1, 3'd2), 4'd1, "R8 fpr split hi");
        // R10 sel 6 and 7
        do_req(mk(5'd1, 5'd2, 5'd0, 1'b1, 1'b0, 3'd6), 4'd1, "R10 sel6");
        do_req(mk(5'd1, 5'd2, 5'd0, 1'b1, 1'b0, 3'd7), 4'd1, "R10 sel7");
        // R1 reserved encodings
        do_req(mk(5'd1, 5'd2, 5'd0, 1'b1, 1'b0, 3'd0) | 32'h8, 4'd1, "R1 bit3");
        do_req(mk(5'd1, 5'd2, 5'd0, 1'b1, 1'b0, 3'd0) ^ 32'h0020_0000, 4'd1, "R1 subop");
        // R2 unusable
        cop_en = 1'b0;
        do_req(mk(5'd1, 5'd2, 5'd0, 1'b1, 1'b0, 3'd0), 4'd1, "R2 unusable");
        cop_en = 1'b1;
        // R3 foreign binding, target running: no stall
        priv = 1'b0; issuer = 1'b0; bindv = 6'b001000; halted = 6'b110111;
        do_req(mk(5'd1, 5'd2, 5'd0, 1'b1, 1'b0, 3'd0), 4'd3, "R3 foreign");
        halted = '1;
        // R4 range: above top, and beyond the physical count
        bindv = '0; top_ctx = 4'd3;
        do_req(mk(5'd1, 5'd2, 5'd0, 1'b1, 1'b0, 3'd0), 4'd4, "R4 above top");
        top_ctx = 4'd9;
        do_req(mk(5'd1, 5'd2, 5'd0, 1'b1, 1'b0, 3'd0), 4'd7, "R4 no context");
        top_ctx = 4'd5; priv = 1'b1;
        // R11 stall on a running context
        halted = 6'b111011;
        @(negedge clk);
        ins = mk(5'd9, 5'd10, 5'd0, 1'b1, 1'b0, 3'd0);
        instr = ins; tgt = 4'd2; req_valid = 1'b1;
        e = expect_of(ins, 4'd2);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(!req_ready && !bank_rd_en, "R11 stall", 64'(req_ready), 64'd0);
        end
        halted = '1;
        #1 check(req_ready, "R11 release", 64'(req_ready), 64'd1);
        finish_req(e, ins[15:11], "R11 after release");

        // random mix
        for (int n = 0; n < 400; n++) begin
            r = $urandom();
            ins = r;
            ins[31:21] = {6'b010000, 5'b01000};
            ins[3] = 1'b0;
            if (r[31:28] == 4'h0) ins[3] = 1'b1;
            if (r[31:28] == 4'h1) ins[26] = 1'b1;
            r = $urandom();
            cop_en   = (r[3:0] != 4'h0);
            priv     = r[4];
            issuer   = r[5];
            bindv    = r[11:6];
            fp_split = r[12];
            top_ctx  = 4'(2 + (r[15:13] % 6));
            do_req(ins, 4'(r[19:16] % 9), "R9 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule